// File: doc/BRIEF.md
# Multi-core boot release controller

This block is a small register window, 1 KiB wide, that sits beside a cluster of up to four processor cores. Software uses it to start a secondary core. It first stores an entry address, plus a general control word and a standby flag. It then writes any non-zero value into that core's reset register. The block answers with a boot request. The request names the core, carries the stored entry address and sets the target privilege level to 3. It also carries an execution-state bit, taken from a per-core "64-bit capable" input, so each core starts in its natural state.

Most of the other registers in the window report fixed values. Each core's release register reads as released, each core's status register reads as running in SMP mode, and the clock-gating and cluster-reset registers read as constants. Four offsets are decoded but have no function: they raise a sticky "unimplemented" flag. Any other offset, and any access narrower than a full word, raises a sticky access-error flag.

The bus is a plain request/ready port. The block takes one access per accept, answers with `bus_rdy` one cycle later, and returns the read data from a register.

Top module: `cluster_boot_ctrl`

## Requirements
- R1: After reset, the general control register (offset 0x184) reads 0x00000020, the standby flag (0x1A0) reads 0 and the entry address (0x1A4) reads 0. In the same state, `boot_valid`, `err_flag` and `unimp_flag` are all 0.
- R2: Offsets 0x184, 0x1A0 and 0x1A4 are full 32-bit read/write registers. Each read returns the last full-word value written to that register.
- R3: Offsets 0x000 and 0x140 read 0x00000001 and offset 0x144 reads 0x0000010F. Writes to these three offsets change nothing.
- R4: Core n (n = 0..3) owns a group of three registers at base 0x40·(n+1): release at +0x0, control at +0x4 and status at +0x8. Release reads 0x3, control reads 0 and status reads 0x1. Writes to control and status change nothing and start no boot request.
- R5: A full-word write of a non-zero value to core n's release register raises `boot_valid` on the same edge that raises `bus_rdy`. With it, `boot_core` = n, `boot_addr` = the entry address register, `boot_el` = 2'b11 and `boot_aa64` = `core_is64[n]`.
- R6: A write of zero to a release register starts no boot request.
- R7: `boot_valid` and its fields stay unchanged until the cycle in which `boot_ack` is high, and drop on the following edge. An ack given in the first cycle therefore gives a one-cycle pulse.
- R8: A non-zero release write that arrives while a request is pending is held off: `bus_rdy` stays low. The edge after the one that takes the ack accepts the write, and the new request appears then. `boot_valid` is low for one cycle in between.
- R9: Offsets 0x1E4, 0x280, 0x284 and 0x288 read 0 and ignore writes. They set `unimp_flag`, which stays set until reset, and they do not set `err_flag`.
- R10: Every other offset, and any access with `bus_be` not equal to 4'b1111, reads 0 and writes nothing. Such an access also starts no boot request and sets `err_flag`, which stays set until reset.
- R11: The block accepts an access on an edge where `bus_req` is 1 and `bus_rdy` is 0, unless R8 holds it off. `bus_rdy` is then 1 for exactly one cycle, and `bus_rdata` holds the read value during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until `bus_rdy` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte offset in the window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdy | output | 1 | One-cycle completion strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid with `bus_rdy` |
| core_is64 | input | NCORES (4) | Per-core 64-bit capable flag |
| boot_valid | output | 1 | Boot request pending |
| boot_core | output | 2 | Index of the core to start |
| boot_addr | output | DATA_W (32) | Entry address for the core |
| boot_el | output | 2 | Target privilege level (3) |
| boot_aa64 | output | 1 | Start in 64-bit state |
| boot_ack | input | 1 | Consumer takes the pending request |
| unimp_flag | output | 1 | Sticky: decoded-but-unimplemented offset used |
| err_flag | output | 1 | Sticky: bad offset or partial-word access |

## Verification
The bench builds the block with all four cores present (NCORES = 4), so every release, control and status group can be reached, and each core can be launched with its own entry address. It uses strict size checking (STRICT_SIZE = 1), which brings partial byte-enable writes within reach as error cases. It also keeps the default general-control reset value. The `core_is64` pattern 4'b1010 mixes both execution states across the cores. A stalled second launch then shows that the hold-off and the one-cycle gap happen where R8 places them.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   localparam int MAX_CORES = 4;
   localparam int CORE_W    = 2;

   // register window offsets whose decode is behaviour (fixed map)
   localparam int OFF_CLUSTER = 'h000;
   localparam int OFF_GRP0    = 'h040;
   localparam int GRP_STRIDE  = 'h040;
   localparam int OFF_SYSRST  = 'h140;
   localparam int OFF_GATING  = 'h144;
   localparam int OFF_GENCTL  = 'h184;
   localparam int OFF_STANDBY = 'h1A0;
   localparam int OFF_ENTRY   = 'h1A4;
   localparam int OFF_DEBUG   = 'h1E4;
   localparam int OFF_CNTCTL  = 'h280;
   localparam int OFF_CNTLO   = 'h284;
   localparam int OFF_CNTHI   = 'h288;

   localparam logic [31:0] VAL_RELEASED = 32'h0000_0003;
   localparam logic [31:0] VAL_SMP      = 32'h0000_0001;
   localparam logic [31:0] VAL_ONE      = 32'h0000_0001;
   localparam logic [31:0] VAL_GATING   = 32'h0000_010F;

   typedef enum logic [2:0] {
      RK_CONST,
      RK_GEN,
      RK_STBY,
      RK_ENTRY,
      RK_LAUNCH,
      RK_UNIMP,
      RK_BAD
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e          kind;
      logic [31:0]        cval;
      logic [CORE_W-1:0]  core;
   } dec_t;

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
   import cbc_pkg::*;
#(
   parameter int NCORES      = 4,
   parameter int ADDR_W      = 10,
   parameter bit STRICT_SIZE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        be,
   output dec_t              dec
);

   logic [NCORES-1:0] hit_rel;
   logic [NCORES-1:0] hit_ctl;
   logic [NCORES-1:0] hit_sts;
   logic              size_bad;

   for (genvar i = 0; i < NCORES; i++) begin : g_grp
      localparam int BASE = OFF_GRP0 + GRP_STRIDE * i;
      assign hit_rel[i] = (addr == ADDR_W'(BASE));
      assign hit_ctl[i] = (addr == ADDR_W'(BASE + 4));
      assign hit_sts[i] = (addr == ADDR_W'(BASE + 8));
   end

   if (STRICT_SIZE) begin : g_strict
      assign size_bad = (be != 4'b1111);
   end else begin : g_loose
      assign size_bad = 1'b0;
   end

   always_comb begin
      dec = '{kind: RK_BAD, cval: '0, core: '0};
      if (|hit_rel) begin
         dec.kind = RK_LAUNCH;
         dec.cval = VAL_RELEASED;
         for (int i = 0; i < NCORES; i++) begin
            if (hit_rel[i]) dec.core = CORE_W'(i);
         end
      end else if (|hit_ctl) begin
         dec.kind = RK_CONST;
      end else if (|hit_sts) begin
         dec.kind = RK_CONST;
         dec.cval = VAL_SMP;
      end else begin
         case (addr)
            ADDR_W'(OFF_CLUSTER),
            ADDR_W'(OFF_SYSRST):  begin dec.kind = RK_CONST; dec.cval = VAL_ONE;    end
            ADDR_W'(OFF_GATING):  begin dec.kind = RK_CONST; dec.cval = VAL_GATING; end
            ADDR_W'(OFF_GENCTL):  dec.kind = RK_GEN;
            ADDR_W'(OFF_STANDBY): dec.kind = RK_STBY;
            ADDR_W'(OFF_ENTRY):   dec.kind = RK_ENTRY;
            ADDR_W'(OFF_DEBUG),
            ADDR_W'(OFF_CNTCTL),
            ADDR_W'(OFF_CNTLO),
            ADDR_W'(OFF_CNTHI):   dec.kind = RK_UNIMP;
            default:              dec.kind = RK_BAD;
         endcase
      end
      if (size_bad) begin
         dec = '{kind: RK_BAD, cval: '0, core: '0};
      end
   end

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
   import cbc_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter logic [31:0] GEN_RST = 32'h0000_0020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  reg_kind_e         kind,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] gen_q,
   output logic [DATA_W-1:0] stby_q,
   output logic [DATA_W-1:0] entry_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_q   <= DATA_W'(GEN_RST);
         stby_q  <= '0;
         entry_q <= '0;
      end else if (we) begin
         case (kind)
            RK_GEN:   gen_q   <= wdata;
            RK_STBY:  stby_q  <= wdata;
            RK_ENTRY: entry_q <= wdata;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/cbc_launch.sv
module cbc_launch
   import cbc_pkg::*;
#(
   parameter int         NCORES  = 4,
   parameter int         DATA_W  = 32,
   parameter logic [1:0] BOOT_EL = 2'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [CORE_W-1:0] core_in,
   input  logic [DATA_W-1:0] addr_in,
   input  logic [NCORES-1:0] is64,
   input  logic              ack,
   output logic              valid,
   output logic [CORE_W-1:0] core,
   output logic [DATA_W-1:0] addr,
   output logic              aa64,
   output logic [1:0]        el
);

   logic sel64;

   always_comb begin
      sel64 = 1'b0;
      for (int i = 0; i < NCORES; i++) begin
         if (core_in == CORE_W'(i)) sel64 = is64[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         core  <= '0;
         addr  <= '0;
         aa64  <= 1'b0;
      end else if (fire) begin
         valid <= 1'b1;
         core  <= core_in;
         addr  <= addr_in;
         aa64  <= sel64;
      end else if (ack) begin
         valid <= 1'b0;
      end
   end

   assign el = BOOT_EL;

endmodule

// File: rtl/cluster_boot_ctrl.sv
module cluster_boot_ctrl
   import cbc_pkg::*;
#(
   parameter int          NCORES      = 4,
   parameter int          ADDR_W      = 10,
   parameter int          DATA_W      = 32,
   parameter bit          STRICT_SIZE = 1'b1,
   parameter logic [31:0] GEN_RST     = 32'h0000_0020,
   parameter logic [1:0]  BOOT_EL     = 2'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_rdy,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NCORES-1:0] core_is64,
   output logic              boot_valid,
   output logic [CORE_W-1:0] boot_core,
   output logic [DATA_W-1:0] boot_addr,
   output logic [1:0]        boot_el,
   output logic              boot_aa64,
   input  logic              boot_ack,
   output logic              unimp_flag,
   output logic              err_flag
);

   if (NCORES < 1 || NCORES > MAX_CORES) begin : g_bad_ncores
      $error("cluster_boot_ctrl: NCORES must be 1..4");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("cluster_boot_ctrl: ADDR_W must cover a 1 KiB window");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("cluster_boot_ctrl: DATA_W must be 32");
   end

   dec_t              dec;
   logic              launch_wr;
   logic              stall;
   logic              accept;
   logic              we;
   logic [DATA_W-1:0] gen_q, stby_q, entry_q;
   logic [DATA_W-1:0] rd_val;

   cbc_decode #(
      .NCORES(NCORES), .ADDR_W(ADDR_W), .STRICT_SIZE(STRICT_SIZE)
   ) u_dec (
      .addr(bus_addr), .be(bus_be), .dec(dec)
   );

   assign launch_wr = (dec.kind == RK_LAUNCH) && bus_wr && (|bus_wdata);
   assign stall     = launch_wr && boot_valid;
   assign accept    = bus_req && !bus_rdy && !stall;
   assign we        = accept && bus_wr;

   cbc_regs #(
      .DATA_W(DATA_W), .GEN_RST(GEN_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .kind(dec.kind), .wdata(bus_wdata),
      .gen_q(gen_q), .stby_q(stby_q), .entry_q(entry_q)
   );

   cbc_launch #(
      .NCORES(NCORES), .DATA_W(DATA_W), .BOOT_EL(BOOT_EL)
   ) u_launch (
      .clk(clk), .rst_n(rst_n), .fire(accept && launch_wr),
      .core_in(dec.core), .addr_in(entry_q), .is64(core_is64), .ack(boot_ack),
      .valid(boot_valid), .core(boot_core), .addr(boot_addr),
      .aa64(boot_aa64), .el(boot_el)
   );

   always_comb begin
      case (dec.kind)
         RK_CONST, RK_LAUNCH: rd_val = DATA_W'(dec.cval);
         RK_GEN:              rd_val = gen_q;
         RK_STBY:             rd_val = stby_q;
         RK_ENTRY:            rd_val = entry_q;
         default:             rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdy    <= 1'b0;
         bus_rdata  <= '0;
         unimp_flag <= 1'b0;
         err_flag   <= 1'b0;
      end else begin
         bus_rdy   <= accept;
         bus_rdata <= (accept && !bus_wr) ? rd_val : '0;
         if (accept && dec.kind == RK_UNIMP) unimp_flag <= 1'b1;
         if (accept && dec.kind == RK_BAD)   err_flag   <= 1'b1;
      end
   end

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_req,
   input logic        bus_rdy,
   input logic        boot_valid,
   input logic        boot_ack,
   input logic [1:0]  boot_core,
   input logic [31:0] boot_addr,
   input logic        boot_aa64,
   input logic        unimp_flag,
   input logic        err_flag
);

   // R11: ready is a single-cycle strobe
   a_r11_rdy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdy |=> !bus_rdy);

   // R11: ready only answers a request
   a_r11_rdy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdy |-> $past(bus_req));

   // R5: a new request appears together with the completing access
   a_r5_rise_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_valid) |-> bus_rdy);

   // R7: request fields hold while unacknowledged
   a_r7_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_valid && !boot_ack) |=> (boot_valid && $stable(boot_core)
                                     && $stable(boot_addr) && $stable(boot_aa64)));

   // R8: an acknowledged request is always followed by an idle cycle
   a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_valid && boot_ack) |=> !boot_valid);

   // R9: unimplemented flag is sticky
   a_r9_unimp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unimp_flag |=> unimp_flag);

   // R10: error flag is sticky
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

endmodule

bind cluster_boot_ctrl cbc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_rdy(bus_rdy),
   .boot_valid(boot_valid), .boot_ack(boot_ack), .boot_core(boot_core),
   .boot_addr(boot_addr), .boot_aa64(boot_aa64),
   .unimp_flag(unimp_flag), .err_flag(err_flag)
);

// File: tb/sim_cluster_boot_ctrl.sv
module sim_cluster_boot_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [3:0]  bus_be = 4'hF;
   logic [31:0] bus_wdata = '0;
   logic        bus_rdy;
   logic [31:0] bus_rdata;
   logic [3:0]  core_is64 = 4'b1010;
   logic        boot_valid;
   logic [1:0]  boot_core;
   logic [31:0] boot_addr;
   logic [1:0]  boot_el;
   logic        boot_aa64;
   logic        boot_ack = 1'b0;
   logic        unimp_flag;
   logic        err_flag;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   cluster_boot_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .core_is64(core_is64),
      .boot_valid(boot_valid), .boot_core(boot_core), .boot_addr(boot_addr),
      .boot_el(boot_el), .boot_aa64(boot_aa64), .boot_ack(boot_ack),
      .unimp_flag(unimp_flag), .err_flag(err_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // one access; returns at the negedge where bus_rdy is seen high
   task automatic bus_op(input logic wr, input logic [9:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd);
      bit got = 1'b0;
      bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
      for (int i = 0; i < 16 && !got; i++) begin
         @(posedge clk); @(negedge clk);
         if (bus_rdy) got = 1'b1;
      end
      rd = bus_rdata;
      bus_req = 1'b0; bus_wr = 1'b0;
      chk("R11 ready seen", {31'b0, got}, 32'd1);
   endtask

   task automatic wr32(input logic [9:0] a, input logic [31:0] d);
      logic [31:0] dummy;
      bus_op(1'b1, a, 4'hF, d, dummy);
   endtask

   task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bus_op(1'b0, a, 4'hF, '0, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset;
      chk("R1 boot_valid", {31'b0, boot_valid}, 0);
      chk("R1 err_flag", {31'b0, err_flag}, 0);
      chk("R1 unimp_flag", {31'b0, unimp_flag}, 0);
      chk("R11 rdy idle", {31'b0, bus_rdy}, 0);
      rd_chk("R1 genctl", 10'h184, 32'h20);
      rd_chk("R1 standby", 10'h1A0, 32'h0);
      rd_chk("R1 entry", 10'h1A4, 32'h0);
   endtask

   task automatic t_timing;
      logic [31:0] v;
      bus_op(1'b0, 10'h144, 4'hF, '0, v);
      chk("R11 rdata with rdy", v, 32'h10F);
      @(posedge clk); @(negedge clk);
      chk("R11 rdy one cycle", {31'b0, bus_rdy}, 0);
   endtask

   task automatic t_rw;
      wr32(10'h184, 32'hA5A5_0001);
      wr32(10'h1A0, 32'h0000_0001);
      wr32(10'h1A4, 32'h4000_0100);
      rd_chk("R2 genctl", 10'h184, 32'hA5A5_0001);
      rd_chk("R2 standby", 10'h1A0, 32'h1);
      rd_chk("R2 entry", 10'h1A4, 32'h4000_0100);
      wr32(10'h1A4, 32'hFFFF_FFFC);
      rd_chk("R2 entry rewrite", 10'h1A4, 32'hFFFF_FFFC);
   endtask

   task automatic t_fixed;
      rd_chk("R3 cluster", 10'h000, 32'h1);
      rd_chk("R3 sysrst", 10'h140, 32'h1);
      rd_chk("R3 gating", 10'h144, 32'h10F);
      wr32(10'h000, 32'h0);
      wr32(10'h140, 32'h0);
      wr32(10'h144, 32'h0);
      rd_chk("R3 cluster after write", 10'h000, 32'h1);
      rd_chk("R3 sysrst after write", 10'h140, 32'h1);
      rd_chk("R3 gating after write", 10'h144, 32'h10F);
      chk("R3 no error", {31'b0, err_flag}, 0);
   endtask

   task automatic t_groups;
      for (int n = 0; n < 4; n++) begin
         logic [9:0] b;
         b = 10'(32'h40 * (n + 1));
         rd_chk("R4 release", b, 32'h3);
         rd_chk("R4 control", b + 10'd4, 32'h0);
         rd_chk("R4 status", b + 10'd8, 32'h1);
         wr32(b + 10'd4, 32'hFFFF_FFFF);
         wr32(b + 10'd8, 32'h0);
         rd_chk("R4 control after write", b + 10'd4, 32'h0);
         rd_chk("R4 status after write", b + 10'd8, 32'h1);
         chk("R4 no launch", {31'b0, boot_valid}, 0);
      end
   endtask

   task automatic t_launch;
      for (int n = 0; n < 4; n++) begin
         logic [31:0] ea;
         ea = 32'h1000_0000 + 32'(n) * 32'h100;
         wr32(10'h1A4, ea);
         wr32(10'(32'h40 * (n + 1)), 32'h1);
         chk("R5 valid", {31'b0, boot_valid}, 1);
         chk("R5 core", {30'b0, boot_core}, 32'(n));
         chk("R5 addr", boot_addr, ea);
         chk("R5 level", {30'b0, boot_el}, 32'd3);
         chk("R5 aa64", {31'b0, boot_aa64}, {31'b0, core_is64[n]});
         boot_ack = 1'b1;
         @(posedge clk); @(negedge clk);
         boot_ack = 1'b0;
         chk("R7 single pulse", {31'b0, boot_valid}, 0);
      end
   endtask

   task automatic t_zero;
      wr32(10'h0C0, 32'h0);
      chk("R6 no request", {31'b0, boot_valid}, 0);
      @(posedge clk); @(negedge clk);
      chk("R6 still none", {31'b0, boot_valid}, 0);
   endtask

   task automatic t_hold;
      wr32(10'h1A4, 32'h2000_0040);
      wr32(10'h080, 32'h8000_0000);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); @(negedge clk);
         chk("R7 held valid", {31'b0, boot_valid}, 1);
         chk("R7 held core", {30'b0, boot_core}, 32'd1);
      end
      wr32(10'h1A4, 32'h3000_0080);
      chk("R7 addr captured", boot_addr, 32'h2000_0040);
      // second launch while pending
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 10'h0C0; bus_be = 4'hF; bus_wdata = 32'h5;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); @(negedge clk);
         chk("R8 stalled", {31'b0, bus_rdy}, 0);
         chk("R8 old core kept", {30'b0, boot_core}, 32'd1);
      end
      boot_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      boot_ack = 1'b0;
      chk("R8 still stalled at ack edge", {31'b0, bus_rdy}, 0);
      chk("R8 gap cycle", {31'b0, boot_valid}, 0);
      @(posedge clk); @(negedge clk);
      chk("R8 accepted", {31'b0, bus_rdy}, 1);
      chk("R8 new valid", {31'b0, boot_valid}, 1);
      chk("R8 new core", {30'b0, boot_core}, 32'd2);
      chk("R8 new addr", boot_addr, 32'h3000_0080);
      bus_req = 1'b0; bus_wr = 1'b0;
      boot_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      boot_ack = 1'b0;
      chk("R7 dropped", {31'b0, boot_valid}, 0);
   endtask

   task automatic t_unimp;
      rd_chk("R9 debug reads 0", 10'h1E4, 32'h0);
      chk("R9 unimp set", {31'b0, unimp_flag}, 1);
      chk("R9 no err", {31'b0, err_flag}, 0);
      wr32(10'h280, 32'hFFFF_FFFF);
      rd_chk("R9 counter ctl reads 0", 10'h280, 32'h0);
      rd_chk("R9 counter lo reads 0", 10'h284, 32'h0);
      rd_chk("R9 counter hi reads 0", 10'h288, 32'h0);
      rd_chk("R9 sticky after normal access", 10'h184, 32'hA5A5_0001);
      chk("R9 still set", {31'b0, unimp_flag}, 1);
   endtask

   task automatic t_err;
      logic [31:0] v;
      rd_chk("R10 hole reads 0", 10'h0CC, 32'h0);
      chk("R10 err set", {31'b0, err_flag}, 1);
      wr32(10'h185, 32'h0);
      rd_chk("R10 misaligned no write", 10'h184, 32'hA5A5_0001);
      bus_op(1'b1, 10'h184, 4'b0011, 32'h0, v);
      rd_chk("R10 partial no write", 10'h184, 32'hA5A5_0001);
      bus_op(1'b0, 10'h184, 4'b1110, 32'h0, v);
      chk("R10 partial read 0", v, 32'h0);
      bus_op(1'b1, 10'h100, 4'b0001, 32'h1, v);
      chk("R10 partial no launch", {31'b0, boot_valid}, 0);
      chk("R10 still set", {31'b0, err_flag}, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_timing();
      t_rw();
      t_fixed();
      t_groups();
      t_launch();
      t_zero();
      t_hold();
      t_unimp();
      t_err();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule